// File: doc/BRIEF.md
# Clock Configuration Register with PLL Update Control

This block holds the clock setup for three PLLs: the main PLL that clocks the processor and memory controller, a video PLL, and a communications PLL. It also decides when a new setting reaches each PLL. Software writes one control word through a simple write strobe. The word carries a 6-bit main-PLL frequency code, an update-mode flag, a video enable with a one-bit rate select, and a comms enable. The block drives the PLL configuration pins from registered state.

A main-PLL frequency write can reach the PLL in one of two ways. It can go out at once, which is allowed only when the PLL is known to come out of lock cleanly. Otherwise it is parked in a shadow register and applied on the next deep-sleep entry from the power manager. Any change on the main-PLL pins makes the PLL lose lock. The block therefore raises a clock-mute request until a synchronised lock-detect shows the PLL is stable again. While the clock is muted it also suppresses the half-rate bus clock enable. The video and comms enables clear on reset and on deep-sleep entry, and only software sets them again. The video rate select moves to the PLL only while that PLL is disabled.

Top module: `clk_cfg_regs`

## Requirements
- R1: After reset, main_freq_o equals the default code 32, rd_data reads 32 in bits [5:0] and 0 in all other bits, vid_en_o, vid_sel_o and com_en_o are 0, clk_mute_o is 1 and bclk_en_o is 0.
- R2: A write whose bit 6 is 1, made in a cycle without sleep_enter, drives bits [5:0] of that write onto main_freq_o after the same clock edge and clears the pending flag (rd_data bit 10).
- R3: A write whose bit 6 is 0 leaves main_freq_o unchanged, shows the written code in rd_data[5:0] and sets rd_data bit 10. A later sleep_enter copies the held code to main_freq_o and clears bit 10.
- R4: When wr_en and sleep_enter are both high in the same cycle, the write is ignored and only the sleep action takes place.
- R5: Whenever main_freq_o changes value, clk_mute_o is 1 in that same cycle. It stays 1 until the synchronised pll_lock has been seen low and then high. It falls two clock edges after pll_lock rises, and it is also 1 whenever the synchronised lock is low.
- R6: bclk_en_o is 0 while clk_mute_o is 1. Otherwise it alternates 0,1,0,1 and starts at 0 in the first unmuted cycle, which gives a bus clock at half the main rate.
- R7: The video enable (write bit 7, output vid_en_o) becomes 0 on sleep_enter and stays 0 until a write sets it.
- R8: The comms enable (write bit 9, output com_en_o) becomes 0 on sleep_enter and stays 0 until a write sets it.
- R9: The written video select (bit 8) reaches vid_sel_o only in an edge where vid_en_o was 0 just before. A select written while the PLL is enabled is held back until the enable clears.
- R10: rd_data reads the held frequency code in [5:0], the mode flag in bit 6, the video enable in bit 7, the written video select in bit 8, the comms enable in bit 9 and the pending flag in bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, ungated source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 10 | Control word written |
| sleep_enter | input | 1 | One-cycle pulse at deep-sleep entry |
| pll_lock | input | 1 | Main-PLL lock detect, asynchronous |
| rd_data | output | 11 | Control register readback with pending flag |
| main_freq_o | output | 6 | Main-PLL frequency code pins |
| vid_en_o | output | 1 | Video PLL enable |
| vid_sel_o | output | 1 | Video PLL rate select |
| com_en_o | output | 1 | Comms PLL enable |
| clk_mute_o | output | 1 | Main clock mute request to the clock gate |
| bclk_en_o | output | 1 | Bus clock enable, half rate |

## Verification
The assertions check these on every cycle: the direct and held paths for the frequency code, the clearing of both enables and of the pending flag by sleep, the freeze of the video select while that PLL is enabled, the mute that accompanies every change of the frequency pins, and the strict alternation of the bus enable. Some behaviour shows only in the bench scenarios. This covers the exact two-edge release of the mute after lock returns, the case of a rewrite with the same frequency, which must not mute, a write that collides with a sleep pulse, and the moment a held select is finally released.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned FREQ_W_DEF   = 6;
  localparam int unsigned FREQ_RST_DEF = 32;

  typedef struct packed {
    logic ven;
    logic vsel;
    logic cen;
  } aux_cfg_t;
endpackage

// File: rtl/clk_cfg_main.sv
module clk_cfg_main #(
  parameter int unsigned FW  = 6,
  parameter int unsigned DEF = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_freq,
  input  logic          wr_imm,
  input  logic          sleep_enter,
  output logic [FW-1:0] main_freq_o,
  output logic [FW-1:0] shadow_o,
  output logic          imm_o,
  output logic          pend_o,
  output logic          upd_o
);
  localparam logic [FW-1:0] RST_CODE = FW'(DEF);

  logic [FW-1:0] main_q, main_d, shadow_q, shadow_d;
  logic          imm_q, imm_d, pend_q, pend_d;

  always_comb begin
    main_d   = main_q;
    shadow_d = shadow_q;
    imm_d    = imm_q;
    pend_d   = pend_q;
    if (sleep_enter) begin
      if (pend_q) begin
        main_d = shadow_q;
        pend_d = 1'b0;
      end
    end else if (wr_en) begin
      shadow_d = wr_freq;
      imm_d    = wr_imm;
      if (wr_imm) begin
        main_d = wr_freq;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end
  end

  assign upd_o = (main_d != main_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q   <= RST_CODE;
      shadow_q <= RST_CODE;
      imm_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      main_q   <= main_d;
      shadow_q <= shadow_d;
      imm_q    <= imm_d;
      pend_q   <= pend_d;
    end
  end

  assign main_freq_o = main_q;
  assign shadow_o    = shadow_q;
  assign imm_o       = imm_q;
  assign pend_o      = pend_q;

  // R2: direct path lands on the pins next edge
  a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_imm && !sleep_enter) |=> (main_freq_o == $past(wr_freq) && !pend_o));
  // R3: deferred write never disturbs the pins
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_imm && !sleep_enter) |=> $stable(main_freq_o));
  // R3: sleep always consumes the pending update
  a_r3_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> !pend_o);
  // R4: a write colliding with sleep leaves the held code alone
  a_r4_collide: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> $stable(shadow_o));
endmodule

// File: rtl/clk_cfg_aux.sv
module clk_cfg_aux
  import clk_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  aux_cfg_t wr_cfg,
  input  logic     sleep_enter,
  output aux_cfg_t cfg_o,
  output logic     vsel_out_o
);
  aux_cfg_t cfg_q, cfg_d;
  logic     vout_q, vout_d;

  always_comb begin
    cfg_d = cfg_q;
    if (sleep_enter) begin
      cfg_d.ven = 1'b0;
      cfg_d.cen = 1'b0;
    end else if (wr_en) begin
      cfg_d = wr_cfg;
    end
    vout_d = cfg_q.ven ? vout_q : cfg_d.vsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      vout_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      vout_q <= vout_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign vsel_out_o = vout_q;

  // R7 and R8: sleep entry drops both enables
  a_r7_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> (!cfg_o.ven && !cfg_o.cen));
  // R9: select pin frozen while the video PLL runs
  a_r9_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o.ven |=> $stable(vsel_out_o));
endmodule

// File: rtl/clk_cfg_lockmute.sv
module clk_cfg_lockmute (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_lock,
  input  logic upd,
  output logic mute_o,
  output logic bclk_en_o
);
  logic s1_q, s2_q, wait_q, wait_d, tog_q, tog_d, mute;

  assign mute   = wait_q | ~s2_q;
  assign wait_d = upd | (wait_q & s2_q);
  assign tog_d  = mute ? 1'b0 : ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      wait_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      s1_q   <= pll_lock;
      s2_q   <= s1_q;
      wait_q <= wait_d;
      tog_q  <= tog_d;
    end
  end

  assign mute_o    = mute;
  assign bclk_en_o = tog_q & ~mute;

  // R6: unmuted bus enable never stays high two cycles
  a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en_o && !mute_o) |=> !bclk_en_o);
  // R5: a pending lock wait keeps the clock muted
  a_r5_wait_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> mute_o);
endmodule

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_cfg_pkg::*;
#(
  parameter int unsigned FREQ_W   = FREQ_W_DEF,
  parameter int unsigned FREQ_RST = FREQ_RST_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FREQ_W+3:0] wr_data,
  input  logic              sleep_enter,
  input  logic              pll_lock,
  output logic [FREQ_W+4:0] rd_data,
  output logic [FREQ_W-1:0] main_freq_o,
  output logic              vid_en_o,
  output logic              vid_sel_o,
  output logic              com_en_o,
  output logic              clk_mute_o,
  output logic              bclk_en_o
);
  localparam int unsigned IMM_B  = FREQ_W;
  localparam int unsigned VEN_B  = FREQ_W + 1;
  localparam int unsigned VSEL_B = FREQ_W + 2;
  localparam int unsigned CEN_B  = FREQ_W + 3;

  logic [FREQ_W-1:0] shadow;
  logic              imm, pend, upd;
  aux_cfg_t          wr_cfg, cfg;

  assign wr_cfg = '{ven: wr_data[VEN_B], vsel: wr_data[VSEL_B], cen: wr_data[CEN_B]};

  clk_cfg_main #(.FW(FREQ_W), .DEF(FREQ_RST)) u_main (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_freq(wr_data[FREQ_W-1:0]), .wr_imm(wr_data[IMM_B]),
    .sleep_enter(sleep_enter), .main_freq_o(main_freq_o),
    .shadow_o(shadow), .imm_o(imm), .pend_o(pend), .upd_o(upd)
  );

  clk_cfg_aux u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
    .sleep_enter(sleep_enter), .cfg_o(cfg), .vsel_out_o(vid_sel_o)
  );

  clk_cfg_lockmute u_lock (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .upd(upd),
    .mute_o(clk_mute_o), .bclk_en_o(bclk_en_o)
  );

  assign vid_en_o = cfg.ven;
  assign com_en_o = cfg.cen;
  assign rd_data  = {pend, cfg.cen, cfg.vsel, cfg.ven, imm, shadow};

  // R5: any movement of the frequency pins is covered by mute
  a_r5_change_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    (main_freq_o != $past(main_freq_o)) |-> clk_mute_o);
endmodule

// File: tb/sim_clk_cfg_regs.sv
module sim_clk_cfg_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic       sleep_enter = 1'b0;
  logic       pll_lock = 1'b0;
  logic [10:0] rd_data;
  logic [5:0] main_freq_o;
  logic       vid_en_o, vid_sel_o, com_en_o, clk_mute_o, bclk_en_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  clk_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sleep_enter(sleep_enter), .pll_lock(pll_lock), .rd_data(rd_data),
    .main_freq_o(main_freq_o), .vid_en_o(vid_en_o), .vid_sel_o(vid_sel_o),
    .com_en_o(com_en_o), .clk_mute_o(clk_mute_o), .bclk_en_o(bclk_en_o)
  );

  // behavioural reference
  int m_main, m_held, m_imm, m_pend, m_ven, m_vsel, m_vout, m_cen;
  int lockq[$];
  int m_wait, m_tog;

  function automatic int m_mute();
    return (m_wait != 0 || lockq[1] == 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_main = 32; m_held = 32; m_imm = 0; m_pend = 0;
      m_ven = 0; m_vsel = 0; m_vout = 0; m_cen = 0;
      lockq = '{0, 0}; m_wait = 0; m_tog = 0;
    end else begin
      int old_main, old_ven, mute_now, s2_now;
      old_main = m_main; old_ven = m_ven;
      mute_now = m_mute(); s2_now = lockq[1];
      if (sleep_enter) begin
        if (m_pend != 0) begin m_main = m_held; m_pend = 0; end
        m_ven = 0; m_cen = 0;
      end else if (wr_en) begin
        m_held = wr_data[5:0]; m_imm = wr_data[6];
        m_ven = wr_data[7]; m_vsel = wr_data[8]; m_cen = wr_data[9];
        if (wr_data[6]) begin m_main = wr_data[5:0]; m_pend = 0; end
        else m_pend = 1;
      end
      if (old_ven == 0) m_vout = m_vsel;
      m_wait = (m_main != old_main || (m_wait != 0 && s2_now != 0)) ? 1 : 0;
      m_tog = mute_now ? 0 : 1 - m_tog;
      lockq = '{pll_lock, lockq[0]};
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2/R3 main_freq_o", main_freq_o, m_main);
      chk("R5 clk_mute_o", clk_mute_o, m_mute());
      chk("R6 bclk_en_o", bclk_en_o, (m_tog != 0 && m_mute() == 0) ? 1 : 0);
      chk("R7 vid_en_o", vid_en_o, m_ven);
      chk("R8 com_en_o", com_en_o, m_cen);
      chk("R9 vid_sel_o", vid_sel_o, m_vout);
      chk("R10 rd_data", rd_data,
          (m_pend << 10) | (m_cen << 9) | (m_vsel << 8) | (m_ven << 7) | (m_imm << 6) | m_held);
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 5000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [9:0] word(int f, int imm, int ven, int vsel, int cen);
    return {cen[0], vsel[0], ven[0], imm[0], f[5:0]};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [9:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic slp();
    @(negedge clk); sleep_enter = 1'b1;
    @(negedge clk); sleep_enter = 1'b0;
  endtask

  task automatic relock();
    @(negedge clk); pll_lock = 1'b0;
    idle(3);
    pll_lock = 1'b1;
    idle(4);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 main_freq_o", main_freq_o, 32);
    chk("R1 rd_data", rd_data, 32);
    chk("R1 clk_mute_o", clk_mute_o, 1);
    chk("R1 bclk_en_o", bclk_en_o, 0);
    pll_lock = 1'b1;
    idle(6);
    // R3: deferred write, enables on
    wr(word(10, 0, 1, 1, 1));
    idle(3);
    chk("R3 pins unchanged", main_freq_o, 32);
    // R9: select change while video enabled is held
    wr(word(10, 0, 1, 0, 1));
    idle(2);
    chk("R9 select held", vid_sel_o, 1);
    // R3 R7 R8: sleep applies held code, clears enables
    slp();
    chk("R3 applied on sleep", main_freq_o, 10);
    chk("R7 ven cleared", vid_en_o, 0);
    relock();
    // R9: select released once disabled, then enable+new select together
    wr(word(10, 0, 0, 1, 0));
    wr(word(10, 0, 1, 0, 0));
    idle(2);
    chk("R9 select follows", vid_sel_o, 0);
    // R2: direct write
    wr(word(50, 1, 1, 0, 1));
    chk("R2 direct", main_freq_o, 50);
    relock();
    // R5: same code again does not mute
    wr(word(50, 1, 1, 0, 1));
    idle(2);
    chk("R5 no mute on same code", clk_mute_o, 0);
    // R4: write collides with sleep
    @(negedge clk); wr_en = 1'b1; sleep_enter = 1'b1; wr_data = word(7, 1, 1, 1, 1);
    @(negedge clk); wr_en = 1'b0; sleep_enter = 1'b0;
    chk("R4 write ignored", main_freq_o, 50);
    chk("R8 cen cleared", com_en_o, 0);
    idle(3);
    // R2: direct write cancels a pending deferred one
    wr(word(20, 0, 0, 0, 0));
    wr(word(40, 1, 0, 0, 0));
    relock();
    slp();
    chk("R2 pending cancelled", main_freq_o, 40);
    idle(4);
    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset again", main_freq_o, 32);
    idle(8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule